// File: doc/BRIEF.md
# Memory Chip-Select Decoder with Wait-State Insertion

This block turns the 20-bit address and the control strobes of an 8-bit-bus processor into active-low chip selects. It also drives a READY line that stretches slow accesses by one clock. The bottom 512K bytes are split into sixteen 32K-byte RAM selects. A primary decoder on the two top address bits enables one of two secondary decoders of eight selects each. The top 96K bytes, which hold the reset start location FFFF0H, are split into three 32K-byte ROM selects. A third secondary decoder, enabled by the primary output for the upper quarter, produces them.

An address-latch pulse `ale` marks the start of each bus cycle. On that edge the block captures the upper address bits and the memory/IO qualifier. From then on, a select is driven only while a read or write strobe is low. Each bus cycle ends when its strobe returns high. A one-bit wait-window register decides which addresses get the one-clock wait. Its reset value applies the wait to the whole upper quarter. Its other value applies the wait only to the ROM addresses.

Top module: `memdec_wait`

## Requirements
- R1: With `io_mem` high (IO cycle), no chip select goes low and `ready` stays high.
- R2: `rom_cs_n[0]`, `rom_cs_n[1]` and `rom_cs_n[2]` select E8000H–EFFFFH, F0000H–F7FFFH and F8000H–FFFFFH respectively.
- R3: For addresses 00000H–7FFFFH, `ram_cs_n[k]` goes low with k = A18..A15. A19..A18 = 00 picks the first bank, `ram_cs_n[7:0]`. A19..A18 = 01 picks the second bank, `ram_cs_n[15:8]`.
- R4: Addresses 80000H–E7FFFH assert no chip select.
- R5: For a qualifying cycle, `ready` is low during exactly the one clock after the edge that samples `ale`, and high again after the following edge.
- R6: With the wait-window bit at 1 (wide), every memory cycle to C0000H–FFFFFH qualifies.
- R7: With the wait-window bit at 0 (narrow), only memory cycles to E8000H–FFFFFH qualify.
- R8: The wait-window bit resets to 1 (wide). It loads `mode_d` on a clock edge where `mode_we` is high.
- R9: Memory cycles to 00000H–BFFFFH never pull `ready` low.
- R10: A chip select is low only while a cycle is active and `rd_n` or `wr_n` is low. At most one select is low at any time.
- R11: After reset, `ready` is high and all selects are high. `ready` is never low outside a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Address bus, sampled when `ale` is high |
| io_mem | input | 1 | 1 = IO cycle, 0 = memory cycle, sampled with `addr` |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address-latch pulse, one clock at cycle start |
| mode_we | input | 1 | Load enable for the wait-window bit |
| mode_d | input | 1 | New wait-window bit: 1 wide, 0 narrow |
| ram_cs_n | output | 16 | RAM block selects, active low |
| rom_cs_n | output | 3 | ROM block selects, active low |
| ready | output | 1 | Low for one clock to insert a wait state |

## Verification
The hardest points to reach are the two window boundaries, C0000H and E8000H, under both settings of the wait-window bit. A decode error there shows only in `ready`, which is low for a single clock, and never in a select. The vector table rewrites the window bit through `mode_we` before every entry. The same addresses are then replayed in wide and in narrow mode, and `ready` is sampled on the exact clock it should be low and on the clock after. Directed tests cover the reset value of the window bit, strobe gating inside an active cycle, and IO cycles to ROM addresses.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W    = 20;
  localparam int BLK_W     = 15;
  localparam int TOP_W     = ADDR_W - BLK_W;
  localparam int PRI_W     = 2;
  localparam int SEC_W     = TOP_W - PRI_W;
  localparam int SEC_N     = 1 << SEC_W;
  localparam int RAM_BANKS = 2;
  localparam int RAM_N     = RAM_BANKS * SEC_N;
  localparam int ROM_N     = 3;
  localparam int ROM_BANK  = (1 << PRI_W) - 1;
  localparam logic [TOP_W-1:0] ROM_FIRST = TOP_W'((1 << TOP_W) - ROM_N);
endpackage

// File: rtl/memdec_onehot.sv
module memdec_onehot #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic             en,
  input  logic [IN_W-1:0]  sel,
  output logic [OUT_N-1:0] y_n
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_out
    assign y_n[i] = !(en && (sel == IN_W'(i)));
  end
endmodule

// File: rtl/memdec_waitgen.sv
module memdec_waitgen
  import memdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic             mode_d,
  input  logic             ale,
  input  logic             io_mem,
  input  logic [TOP_W-1:0] top,
  output logic             ready
);
  logic wide_q, wide_d;
  logic wait_q, wait_d;
  logic in_wide, in_narrow;

  always_comb begin
    in_wide   = (top[TOP_W-1 -: PRI_W] == PRI_W'(ROM_BANK));
    in_narrow = (top >= ROM_FIRST);
    wide_d    = mode_we ? mode_d : wide_q;
    wait_d    = ale && !io_mem && (wide_q ? in_wide : in_narrow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b1;
      wait_q <= 1'b0;
    end else begin
      wide_q <= wide_d;
      wait_q <= wait_d;
    end
  end

  assign ready = !wait_q;
endmodule

// File: rtl/memdec_wait.sv
module memdec_wait
  import memdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_mem,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ale,
  input  logic              mode_we,
  input  logic              mode_d,
  output logic [RAM_N-1:0]  ram_cs_n,
  output logic [ROM_N-1:0]  rom_cs_n,
  output logic              ready
);
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [TOP_W-1:0] top_q, top_d;
  logic             io_q, io_d;
  logic             act_q, act_d;
  logic             seen_q, seen_d;
  logic             strobe;

  always_comb begin
    strobe = !rd_n || !wr_n;
    top_d  = ale ? addr[ADDR_W-1 -: TOP_W] : top_q;
    io_d   = ale ? io_mem : io_q;
    seen_d = ale ? 1'b0 : (seen_q || (act_q && strobe));
    if (ale)                          act_d = 1'b1;
    else if (act_q && seen_q && !strobe) act_d = 1'b0;
    else                              act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      top_q  <= '0;
      io_q   <= 1'b1;
      act_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      top_q  <= top_d;
      io_q   <= io_d;
      act_q  <= act_d;
      seen_q <= seen_d;
    end
  end

  logic              sel_en;
  logic [(1<<PRI_W)-1:0] prim_n;
  logic [SEC_N-1:0]  rom_full_n;

  assign sel_en = act_q && !io_q && strobe;

  memdec_onehot #(.IN_W(PRI_W)) u_prim (
    .en (sel_en),
    .sel(top_q[TOP_W-1 -: PRI_W]),
    .y_n(prim_n)
  );

  for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
    memdec_onehot #(.IN_W(SEC_W)) u_sec (
      .en (!prim_n[b]),
      .sel(top_q[SEC_W-1:0]),
      .y_n(ram_cs_n[b*SEC_N +: SEC_N])
    );
  end

  memdec_onehot #(.IN_W(SEC_W)) u_rom (
    .en (!prim_n[ROM_BANK]),
    .sel(top_q[SEC_W-1:0]),
    .y_n(rom_full_n)
  );
  assign rom_cs_n = rom_full_n[SEC_N-1 -: ROM_N];

  memdec_waitgen u_wait (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .mode_we(mode_we),
    .mode_d (mode_d),
    .ale    (ale),
    .io_mem (io_mem),
    .top    (addr[ADDR_W-1 -: TOP_W]),
    .ready  (ready)
  );
endmodule

// File: rtl/memdec_wait_chk.sv
module memdec_wait_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] addr,
  input logic        io_mem,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ale,
  input logic [15:0] ram_cs_n,
  input logic [2:0]  rom_cs_n,
  input logic        ready
);
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ram_cs_n, rom_cs_n}));

  a_r10_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (&{ram_cs_n, rom_cs_n}));

  a_r11_ready_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $past(ale));

  a_r5_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !ale) |=> ready);

  a_r1_io_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && io_mem) |=> ready);

  a_r9_ram_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !io_mem && (addr[19:18] != 2'b11)) |=> ready);

  a_r7_rom_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !io_mem && (addr[19:15] >= 5'b11101)) |=> !ready);
endmodule

bind memdec_wait memdec_wait_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .io_mem  (io_mem),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .ale     (ale),
  .ram_cs_n(ram_cs_n),
  .rom_cs_n(rom_cs_n),
  .ready   (ready)
);

// File: tb/test_memdec_wait.sv
module test_memdec_wait;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        io_mem = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ale = 1'b0;
  logic        mode_we = 1'b0;
  logic        mode_d = 1'b1;
  logic [15:0] ram_cs_n;
  logic [2:0]  rom_cs_n;
  logic        ready;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  memdec_wait i_memdec_wait (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_mem(io_mem),
    .rd_n(rd_n), .wr_n(wr_n), .ale(ale), .mode_we(mode_we),
    .mode_d(mode_d), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .ready(ready)
  );

  // addr, io, write, wide, expected RAM select (active high), expected ROM select, expected wait
  typedef struct packed {
    logic [19:0] a;
    logic        io;
    logic        wr;
    logic        wide;
    logic [15:0] ram;
    logic [2:0]  rom;
    logic        wt;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{20'h00000, 1'b0, 1'b0, 1'b1, 16'h0001, 3'b000, 1'b0}, // R3 R9
    '{20'h07FFF, 1'b0, 1'b1, 1'b1, 16'h0001, 3'b000, 1'b0}, // R3
    '{20'h08000, 1'b0, 1'b0, 1'b1, 16'h0002, 3'b000, 1'b0}, // R3
    '{20'h3FFFF, 1'b0, 1'b0, 1'b1, 16'h0080, 3'b000, 1'b0}, // R3
    '{20'h40000, 1'b0, 1'b1, 1'b1, 16'h0100, 3'b000, 1'b0}, // R3
    '{20'h7FFFF, 1'b0, 1'b1, 1'b1, 16'h8000, 3'b000, 1'b0}, // R3
    '{20'h80000, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b000, 1'b0}, // R4 R9
    '{20'hBFFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b000, 1'b0}, // R4 R9
    '{20'hC0000, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b000, 1'b1}, // R4 R6
    '{20'hE7FFF, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b000, 1'b1}, // R4 R6
    '{20'hE8000, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b001, 1'b1}, // R2 R6
    '{20'hF0000, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b010, 1'b1}, // R2
    '{20'hFFFF0, 1'b0, 1'b0, 1'b1, 16'h0000, 3'b100, 1'b1}, // R2
    '{20'hC0000, 1'b0, 1'b0, 1'b0, 16'h0000, 3'b000, 1'b0}, // R7
    '{20'hE7FFF, 1'b0, 1'b1, 1'b0, 16'h0000, 3'b000, 1'b0}, // R7
    '{20'hE8000, 1'b0, 1'b0, 1'b0, 16'h0000, 3'b001, 1'b1}, // R7
    '{20'hF7FFF, 1'b0, 1'b0, 1'b0, 16'h0000, 3'b010, 1'b1}, // R7
    '{20'hFFFFF, 1'b0, 1'b1, 1'b0, 16'h0000, 3'b100, 1'b1}, // R7
    '{20'hE8000, 1'b1, 1'b0, 1'b1, 16'h0000, 3'b000, 1'b0}, // R1
    '{20'h00000, 1'b1, 1'b1, 1'b1, 16'h0000, 3'b000, 1'b0}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic wide);
    @(negedge clk);
    mode_we = 1'b1;
    mode_d  = wide;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Runs one bus cycle; checks ready in the wait clock, selects with the strobe low,
  // ready back high one clock later, and all selects released after the strobe.
  task automatic bus_cycle(input logic [19:0] a, input logic io, input logic wr,
                           input logic [15:0] eram, input logic [2:0] erom,
                           input logic ewt, input string req);
    @(negedge clk);
    addr = a; io_mem = io; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    check({req, " ready in wait clock"}, 32'(ready), 32'(!ewt));
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    check({req, " selects"}, {13'd0, ~rom_cs_n, ~ram_cs_n}, {13'd0, erom, eram});
    @(negedge clk);
    check({req, " R5 ready restored"}, 32'(ready), 32'd1);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    check({req, " R10 selects released"}, {13'd0, rom_cs_n, ram_cs_n}, {13'd0, 3'b111, 16'hFFFF});
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset ready", 32'(ready), 32'd1);
        check("R11 reset selects", {13'd0, rom_cs_n, ram_cs_n}, {13'd0, 3'b111, 16'hFFFF});

        // R8: window bit resets to wide, so C0000H waits without any write
        bus_cycle(20'hC0000, 1'b0, 1'b0, 16'h0000, 3'b000, 1'b1, "R8 reset wide");

        for (int i = 0; i < NV; i++) begin
          set_mode(VT[i].wide);
          bus_cycle(VT[i].a, VT[i].io, VT[i].wr, VT[i].ram, VT[i].rom, VT[i].wt,
                    $sformatf("vec%0d", i));
        end

        // R10: active cycle with strobes still high drives no select
        set_mode(1'b1);
        @(negedge clk);
        addr = 20'h40000; io_mem = 1'b0; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        check("R10 no strobe no select", {13'd0, rom_cs_n, ram_cs_n}, {13'd0, 3'b111, 16'hFFFF});
        rd_n = 1'b0;
        #1;
        check("R10 strobe late select", {16'd0, ram_cs_n}, {16'd0, 16'hFEFF});
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);

        // R11: idle bus with ROM address on the pins and no ale keeps ready high
        addr = 20'hFFFF0; io_mem = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 idle ready", 32'(ready), 32'd1);

        // R8: narrow then back to wide through mode_we
        set_mode(1'b0);
        bus_cycle(20'hD0000, 1'b0, 1'b0, 16'h0000, 3'b000, 1'b0, "R8 narrow load");
        set_mode(1'b1);
        bus_cycle(20'hD0000, 1'b0, 1'b0, 16'h0000, 3'b000, 1'b1, "R8 wide load");
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hang expected=done");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule